// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Control Engine

This block runs automatic flow control on the modem lines of a UART whose receive FIFO holds up to 128 characters. On the transmit side it watches a "peer not ready" input (active high means stop). When that input goes high, the block holds the transmitter, but only at a character boundary. On the receive side it drives a "local not ready" output with hysteresis, based on the receive FIFO fill count. The serial shifter, the FIFO storage and the register bus lie outside the block; they connect through plain configuration, count and strobe signals.

The transmit gate is a three-state machine:
- `TX_RUN`: transmission allowed.
- `TX_DRAIN`: the peer asked to stop while a character is in flight, so the block waits for its stop bit.
- `TX_HELD`: the transmitter is held.

The transitions are:
- *stop-request* (`TX_RUN`→`TX_DRAIN`, or straight to `TX_HELD` when idle or at a stop bit).
- *stop-bit-done* (`TX_DRAIN`→`TX_HELD`).
- *release* (any state→`TX_RUN` when the peer line clears or the transmit enable drops).

The receive line is a two-state machine, `RX_ON` and `RX_OFF`, with these transitions:
- *fill-high* (`RX_ON`→`RX_OFF` when the count reaches the high level).
- *drain-low* (`RX_OFF`→`RX_ON` when the count falls to the low level, or the receive enable drops).

A remap bit moves both roles from the CTS/RTS pair to the DSR/DTR pair. A rise of the watched input sets a sticky status flag. That flag drives the interrupt output only when its enable is set.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, `tx_hold`, `rts_o`, `dtr_o`, `stat_flag` and `irq_o` are all 0.
- R2: With transmit flow control enabled and the watched line at 1, `tx_hold` rises one cycle after the line is seen if no character is active, and otherwise one cycle after the cycle in which `tx_stop_done` pulses. It is never asserted while a character is still in flight.
- R3: `tx_hold` returns to 0 one cycle after the watched line is seen at 0, or after transmit flow control is disabled. This also cancels a pending drain.
- R4: A 0-to-1 change of the watched line while transmit flow control is enabled sets `stat_flag` on the next cycle. `stat_clr` clears it, and a set in the same cycle wins over the clear.
- R5: `irq_o` equals `stat_flag` when `irq_en` is 1, and is 0 otherwise.
- R6: With receive flow control enabled, the active ready output goes to 1 one cycle after `rx_count` is at or above the high level.
- R7: The active ready output returns to 0 one cycle after `rx_count` is at or below the low level, or after receive flow control is disabled. Between the two levels it keeps its value, and counts up to 128 are accepted.
- R8: With `cfg_remap`=0 the block watches `cts_i` and drives `rts_o`, and `dtr_o` stays 0. With `cfg_remap`=1 it watches `dsr_i` and drives `dtr_o`, `rts_o` stays 0, and `cts_i` has no effect.
- R9: When `cfg_lvl_tx`, `cfg_lvl_rx`, `cfg_lvl_hi` and `cfg_lvl_lo` are all zero, the high/low pair comes from `cfg_legacy_trig`: 0→8/1, 1→16/8, 2→56/16, 3→60/32. Otherwise the pair is `cfg_lvl_hi`/`cfg_lvl_lo`.
- R10: The transmit and receive enables act independently. With only receive enabled, a high watched line never asserts `tx_hold`. With only transmit enabled, the ready output stays 0 at any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Enable automatic transmit gating |
| cfg_rx_en | input | 1 | Enable automatic receive line control |
| cfg_remap | input | 1 | 1 = use DSR/DTR instead of CTS/RTS |
| cfg_legacy_trig | input | 2 | Legacy trigger-level code |
| cfg_lvl_tx | input | CNT_W | Extended transmit level register (zero test only) |
| cfg_lvl_rx | input | CNT_W | Extended receive level register (zero test only) |
| cfg_lvl_hi | input | CNT_W | Programmable high fill level (1..128) |
| cfg_lvl_lo | input | CNT_W | Programmable low fill level (1..128) |
| rx_count | input | CNT_W | Receive FIFO fill count (0..128) |
| tx_active | input | 1 | A character is being shifted out |
| tx_stop_done | input | 1 | Pulse: stop bit of the current character finished |
| tx_hold | output | 1 | Hold the transmitter before its next character |
| cts_i | input | 1 | Peer not-ready line (1 = stop) |
| dsr_i | input | 1 | Alternate peer not-ready line |
| rts_o | output | 1 | Local not-ready line (1 = off) |
| dtr_o | output | 1 | Alternate local not-ready line |
| irq_en | input | 1 | Interrupt enable for the status flag |
| stat_clr | input | 1 | Pulse: clear the status flag |
| stat_flag | output | 1 | Sticky "peer line rose" flag |
| irq_o | output | 1 | Gated interrupt |

## Verification
The bench builds the block with the default `CNT_W` of 8. With that width it can drive the fill count through the full range 0 to 128. It can also set either level to its extreme of 1 or 128, so both edges of the hysteresis band are reachable. Each level pair is approached from below and from above. Every legacy code is exercised, and so is the case where only one extended register is nonzero. A behavioural model is compared against the outputs on every cycle.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic [1:0] {
        TX_RUN   = 2'd0,
        TX_DRAIN = 2'd1,
        TX_HELD  = 2'd2
    } tx_st_e;

    typedef enum logic {
        RX_ON  = 1'b0,
        RX_OFF = 1'b1
    } rx_st_e;

    function automatic int legacy_hi(input logic [1:0] code);
        unique case (code)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int legacy_lo(input logic [1:0] code);
        unique case (code)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/ufc_thresh.sv
module ufc_thresh #(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       legacy_trig,
    input  logic [CNT_W-1:0] lvl_tx,
    input  logic [CNT_W-1:0] lvl_rx,
    input  logic [CNT_W-1:0] lvl_hi,
    input  logic [CNT_W-1:0] lvl_lo,
    output logic [CNT_W-1:0] hi_lvl,
    output logic [CNT_W-1:0] lo_lvl
);
    import uart_flow_pkg::*;

    logic ext_zero;

    always_comb begin
        ext_zero = (lvl_tx == '0) && (lvl_rx == '0) && (lvl_hi == '0) && (lvl_lo == '0);
        if (ext_zero) begin
            hi_lvl = CNT_W'(legacy_hi(legacy_trig));
            lo_lvl = CNT_W'(legacy_lo(legacy_trig));
        end else begin
            hi_lvl = lvl_hi;
            lo_lvl = lvl_lo;
        end
    end

    // R9: the legacy pair always keeps high above low
    always_comb begin
        if (ext_zero) begin
            p_legacy_order_r9: assert (hi_lvl > lo_lvl);
        end
    end

endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line,
    input  logic active,
    input  logic stop_done,
    output logic hold
);
    import uart_flow_pkg::*;

    tx_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_RUN: begin
                if (en && line) begin
                    if (active && !stop_done) state_nx = TX_DRAIN;
                    else                      state_nx = TX_HELD;
                end
            end
            TX_DRAIN: begin
                if (!en || !line)   state_nx = TX_RUN;
                else if (stop_done) state_nx = TX_HELD;
            end
            TX_HELD: begin
                if (!en || !line) state_nx = TX_RUN;
            end
            default: state_nx = TX_RUN;
        endcase
    end

    always_comb hold = (state == TX_HELD);

    p_no_midchar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DRAIN && !stop_done) |=> (state != TX_HELD));

    p_hold_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(en && line));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !line) |=> !hold);

endmodule

// File: rtl/ufc_rx_line.sv
module ufc_rx_line #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] hi_lvl,
    input  logic [CNT_W-1:0] lo_lvl,
    output logic             off
);
    import uart_flow_pkg::*;

    rx_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_ON;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_ON:  if (en && count >= hi_lvl)  state_nx = RX_OFF;
            RX_OFF: if (!en || count <= lo_lvl) state_nx = RX_ON;
            default: state_nx = RX_ON;
        endcase
    end

    always_comb off = (state == RX_OFF);

    p_off_at_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!off && en && count >= hi_lvl) |=> off);

    p_on_at_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (off && count <= lo_lvl) |=> !off);

    p_rx_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !off);

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx_en,
    input  logic             cfg_rx_en,
    input  logic             cfg_remap,
    input  logic [1:0]       cfg_legacy_trig,
    input  logic [CNT_W-1:0] cfg_lvl_tx,
    input  logic [CNT_W-1:0] cfg_lvl_rx,
    input  logic [CNT_W-1:0] cfg_lvl_hi,
    input  logic [CNT_W-1:0] cfg_lvl_lo,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tx_active,
    input  logic             tx_stop_done,
    output logic             tx_hold,
    input  logic             cts_i,
    input  logic             dsr_i,
    output logic             rts_o,
    output logic             dtr_o,
    input  logic             irq_en,
    input  logic             stat_clr,
    output logic             stat_flag,
    output logic             irq_o
);

    logic             peer_line;
    logic             peer_q;
    logic             line_off;
    logic [CNT_W-1:0] hi_lvl;
    logic [CNT_W-1:0] lo_lvl;

    always_comb peer_line = cfg_remap ? dsr_i : cts_i;

    ufc_thresh #(.CNT_W(CNT_W)) u_thresh (
        .legacy_trig (cfg_legacy_trig),
        .lvl_tx      (cfg_lvl_tx),
        .lvl_rx      (cfg_lvl_rx),
        .lvl_hi      (cfg_lvl_hi),
        .lvl_lo      (cfg_lvl_lo),
        .hi_lvl      (hi_lvl),
        .lo_lvl      (lo_lvl)
    );

    ufc_tx_gate u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_tx_en),
        .line      (peer_line),
        .active    (tx_active),
        .stop_done (tx_stop_done),
        .hold      (tx_hold)
    );

    ufc_rx_line #(.CNT_W(CNT_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_rx_en),
        .count  (rx_count),
        .hi_lvl (hi_lvl),
        .lo_lvl (lo_lvl),
        .off    (line_off)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peer_q    <= 1'b0;
            stat_flag <= 1'b0;
        end else begin
            peer_q <= peer_line;
            if (cfg_tx_en && peer_line && !peer_q) stat_flag <= 1'b1;
            else if (stat_clr)                     stat_flag <= 1'b0;
        end
    end

    always_comb begin
        rts_o = cfg_remap ? 1'b0 : line_off;
        dtr_o = cfg_remap ? line_off : 1'b0;
        irq_o = stat_flag && irq_en;
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_en && peer_line && !peer_q) |=> stat_flag);

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en && stat_flag));

    p_remap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rts_o && dtr_o));

endmodule

// File: tb/uart_flow_ctl_tb.sv
`timescale 1ns/1ps
module uart_flow_ctl_tb;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, rx_en = 0, remap = 0;
    logic [1:0] ltrig = 0;
    logic [CNT_W-1:0] lv_tx = 0, lv_rx = 0, lv_hi = 0, lv_lo = 0, cnt = 0;
    logic act = 0, sdone = 0, cts = 0, dsr = 0, ien = 0, sclr = 0;
    logic hold, rts, dtr, flag, irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_flow_ctl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(tx_en), .cfg_rx_en(rx_en),
        .cfg_remap(remap), .cfg_legacy_trig(ltrig), .cfg_lvl_tx(lv_tx),
        .cfg_lvl_rx(lv_rx), .cfg_lvl_hi(lv_hi), .cfg_lvl_lo(lv_lo),
        .rx_count(cnt), .tx_active(act), .tx_stop_done(sdone), .tx_hold(hold),
        .cts_i(cts), .dsr_i(dsr), .rts_o(rts), .dtr_o(dtr), .irq_en(ien),
        .stat_clr(sclr), .stat_flag(flag), .irq_o(irq)
    );

    // behavioural reference
    bit m_hold, m_wait, m_flag, m_prev, m_off;

    always @(posedge clk) begin
        bit ln;
        int hi, lo;
        if (!rst_n) begin
            m_hold = 0; m_wait = 0; m_flag = 0; m_prev = 0; m_off = 0;
        end else begin
            ln = remap ? dsr : cts;
            if (!tx_en || !ln) begin
                m_hold = 0; m_wait = 0;
            end else if (!m_hold) begin
                if (m_wait) begin
                    if (sdone) begin m_hold = 1; m_wait = 0; end
                end else if (act && !sdone) m_wait = 1;
                else m_hold = 1;
            end
            if (tx_en && ln && !m_prev) m_flag = 1;
            else if (sclr) m_flag = 0;
            m_prev = ln;
            if (lv_tx == 0 && lv_rx == 0 && lv_hi == 0 && lv_lo == 0) begin
                hi = (ltrig == 0) ? 8 : (ltrig == 1) ? 16 : (ltrig == 2) ? 56 : 60;
                lo = (ltrig == 0) ? 1 : (ltrig == 1) ? 8 : (ltrig == 2) ? 16 : 32;
            end else begin
                hi = int'(lv_hi); lo = int'(lv_lo);
            end
            if (!rx_en) m_off = 0;
            else if (!m_off && int'(cnt) >= hi) m_off = 1;
            else if (m_off && int'(cnt) <= lo) m_off = 0;
        end
    end

    task automatic chk(input string req, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 tx_hold", hold, m_hold);
            chk("R4 stat_flag", flag, m_flag);
            chk("R5 irq_o", irq, (m_flag && ien) ? 1 : 0);
            chk("R6 rts_o", rts, (!remap && m_off) ? 1 : 0);
            chk("R8 dtr_o", dtr, (remap && m_off) ? 1 : 0);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic ramp(input int from, input int to);
        if (from <= to) for (int i = from; i <= to; i++) begin cnt = CNT_W'(i); step(); end
        else            for (int i = from; i >= to; i--) begin cnt = CNT_W'(i); step(); end
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step();
        chk("R1 reset hold", hold, 0);
        chk("R1 reset rts", rts, 0);
        chk("R1 reset flag", flag, 0);
        chk("R1 reset irq", irq, 0);

        // legacy levels, all codes
        rx_en = 1;
        for (int c = 0; c < 4; c++) begin
            ltrig = 2'(c);
            ramp(0, 64);
            ramp(64, 0);
        end
        ltrig = 2;
        cnt = 55; step(2);
        chk("R9 below legacy high", rts, 0);
        cnt = 56; step();
        chk("R9 at legacy high", rts, 1);
        cnt = 17; step();
        chk("R7 inside band holds", rts, 1);
        cnt = 16; step();
        chk("R7 at low", rts, 0);

        // programmable levels, extremes
        lv_hi = 128; lv_lo = 1;
        ramp(0, 128);
        chk("R7 full count accepted off", rts, 1);
        ramp(128, 0);
        lv_hi = 100; lv_lo = 40;
        ramp(90, 128); ramp(128, 30);
        lv_hi = 0; lv_lo = 0; lv_tx = 5; ltrig = 0;
        cnt = 7; step(2);
        chk("R9 one ext nonzero selects regs", rts, 1);
        lv_tx = 0; lv_hi = 20; lv_lo = 10;
        cnt = 25; step(2);
        rx_en = 0; step(2);
        chk("R7 disable restores", rts, 0);

        // R10: rx only, watched line high
        rx_en = 1; cts = 1; step(3);
        chk("R10 no hold without tx_en", hold, 0);
        cts = 0; step();

        // transmit gating
        tx_en = 1; rx_en = 0; cnt = 120; step(2);
        chk("R10 rts quiet without rx_en", rts, 0);
        act = 1; cts = 1; step(4);
        chk("R2 held off mid character", hold, 0);
        sdone = 1; step(); sdone = 0; act = 0; step();
        chk("R2 hold after stop bit", hold, 1);
        cts = 0; step();
        chk("R3 release", hold, 0);
        cts = 1; step();
        chk("R2 idle hold immediate", hold, 1);
        cts = 0; act = 1; step(); cts = 1; step(2); tx_en = 0; step();
        chk("R3 disable cancels drain", hold, 0);
        tx_en = 1; cts = 0; act = 0; step();

        // status flag and interrupt
        sclr = 1; step(); sclr = 0;
        ien = 0; cts = 1; step(2);
        chk("R4 flag set", flag, 1);
        chk("R5 irq masked", irq, 0);
        ien = 1; step();
        chk("R5 irq on", irq, 1);
        cts = 0; sclr = 1; step(); sclr = 0; step();
        chk("R4 flag cleared", flag, 0);
        sclr = 1; cts = 1; step(); sclr = 0; step();
        chk("R4 set wins", flag, 1);
        cts = 0; sclr = 1; step(); sclr = 0;

        // remap to DSR/DTR
        remap = 1; rx_en = 1; lv_hi = 30; lv_lo = 5;
        cts = 1; step(3);
        chk("R8 cts ignored when remapped", hold, 0);
        dsr = 1; step(2);
        chk("R8 dsr drives hold", hold, 1);
        ramp(0, 40);
        chk("R8 dtr off", dtr, 1);
        chk("R8 rts quiet", rts, 0);
        ramp(40, 0);
        dsr = 0; cts = 0; remap = 0; step(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule